// File: doc/BRIEF.md
# Period Timer with Delta Stall

This block is a 16-bit up-counting timer that wraps at a programmable period and watches two programmable compare values. Each wrap and each compare match produces a one-cycle strobe and sets a sticky flag. Each flag has a mask bit, and the interrupt request is the OR of the flags whose mask bit is set. Software drives the timer through a byte-wide write port. That port carries the run/mode control, a staged two-byte value path, and the period, compare, flag and mask registers.

The two-byte value path has two meanings. While the timer is stopped it loads the counter. While the timer runs it loads a delta down-counter, and the main count freezes until that down-counter is spent. A single period is stretched by exactly the delta value, which lets software trim when overflows fall without reprogramming the period.

Starting and stopping is either immediate or deferred to a slow reference tick. The tick arrives as a single-cycle synchronous strobe, so run changes can be lined up with a low-rate time base. There is no streaming data path: every pin is a plain control or status signal.

Top module: `stall_period_timer`

## Requirements
- R1: After reset, `running`, `count`, `flags`, `irq`, `ovf_pulse`, `cmp_pulse` and `delta_busy` are all 0. The period and both compare values reset to 0xFFFF and the mask resets to 0.
- R2: A write to address 0 with data bit 1 clear sets `running` to data bit 0 on the next cycle.
- R3: A write to address 0 with data bit 1 set leaves `running` unchanged until the first `ref_tick` in a later cycle. `running` then takes the written bit 0 in the cycle after that tick. A tick in the same cycle as the write does not apply it.
- R4: While running with no stall, `count` rises by 1 each cycle. While idle it holds its value, except when a value write commits.
- R5: When the counter advances from a value equal to the period (address 3 low byte, address 4 high byte), it loads 0. `ovf_pulse` is high for that one cycle, together with `count` = 0, and flag bit 0 is set.
- R6: When an advance brings `count` to compare value k, `cmp_pulse[k]` is high for the cycle in which `count` shows that value, and flag bit 1+k is set. Compare k has its low byte at address 5+2k and its high byte at address 6+2k.
- R7: A write to address 1 stages a low byte. A write to address 2 commits {data, staged byte}, and while idle `count` shows this value on the next cycle.
- R8: A commit while running leaves the counter advancing on the commit edge. It then holds `count` for exactly D cycles, with `delta_busy` high, where D is the committed value. Counting then resumes with no reload, and D = 0 causes no stall.
- R9: A write to address 8+2·(2−2)+1, that is address 9, clears each flag whose data bit is 0 and keeps each flag whose bit is 1. The flag bits are 0 overflow, 1 compare 0 and 2 compare 1. An event in the same cycle as its clear leaves that flag set.
- R10: `irq` is high exactly when some flag is set whose mask bit is also set. The mask is at address 10, in the same bit order as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe of the slow reference time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| running | output | 1 | Timer is in the run state |
| count | output | 16 | Current counter value |
| delta_busy | output | 1 | Delta down-counter is nonzero (counter stalled while running) |
| ovf_pulse | output | 1 | One-cycle overflow strobe |
| cmp_pulse | output | 2 | One-cycle compare-match strobes |
| flags | output | 3 | Sticky event flags |
| irq | output | 1 | Masked interrupt request |

## Verification
Two functions can fall in the same cycle: a software clear of the flags and a hardware event that sets a flag. The bench runs a short period and times a clear-all flag write so that it lands on the edge that produces an overflow. The overflow flag must survive, while an older compare flag with no new event must drop. A second clear on the next edge coincides with a compare match and must leave only that compare flag, with `irq` following the mask. A delta write is also placed on a running counter, and the bench checks that the commit edge still advances before the stall begins.

// File: rtl/spt_pkg.sv
package spt_pkg;
  // Register addresses shared by the decoder and the checker
  localparam int unsigned ADDR_CTRL     = 0;
  localparam int unsigned ADDR_VAL_LO   = 1;
  localparam int unsigned ADDR_VAL_HI   = 2;
  localparam int unsigned ADDR_PER_LO   = 3;
  localparam int unsigned ADDR_PER_HI   = 4;
  localparam int unsigned ADDR_CMP_BASE = 5;

  // Control byte fields
  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_SYNC_BIT = 1;

  // Flag vector layout: bit 0 overflow, bits 1.. compare units
  localparam int unsigned FLAG_OVF = 0;

  function automatic int unsigned cmp_lo_addr(input int unsigned k);
    return ADDR_CMP_BASE + 2 * k;
  endfunction

  function automatic int unsigned flag_addr(input int unsigned ncmp);
    return ADDR_CMP_BASE + 2 * ncmp;
  endfunction

  function automatic int unsigned mask_addr(input int unsigned ncmp);
    return ADDR_CMP_BASE + 2 * ncmp + 1;
  endfunction
endpackage

// File: rtl/spt_regs.sv
module spt_regs
  import spt_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = 4,
  localparam int CNT_W  = 2 * BYTE_W,
  localparam int NEV    = NUM_CMP + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  output logic                     ctrl_wr,
  output logic                     ctrl_run,
  output logic                     ctrl_sync,
  output logic                     val_commit,
  output logic [CNT_W-1:0]         val_word,
  output logic [CNT_W-1:0]         period,
  output logic [NUM_CMP*CNT_W-1:0] cmp_vals,
  output logic [NEV-1:0]           mask,
  output logic                     flag_wr,
  output logic [NEV-1:0]           flag_wdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_VLO  = ADDR_W'(ADDR_VAL_LO);
  localparam logic [ADDR_W-1:0] A_VHI  = ADDR_W'(ADDR_VAL_HI);
  localparam logic [ADDR_W-1:0] A_PLO  = ADDR_W'(ADDR_PER_LO);
  localparam logic [ADDR_W-1:0] A_PHI  = ADDR_W'(ADDR_PER_HI);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(flag_addr(NUM_CMP));
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(mask_addr(NUM_CMP));

  logic [BYTE_W-1:0] lo_q;
  logic [CNT_W-1:0]  per_q;
  logic [NEV-1:0]    mask_q;

  // Control byte is consumed directly on the write cycle
  assign ctrl_wr    = wr_en && (wr_addr == A_CTRL);
  assign ctrl_run   = wr_data[CTRL_RUN_BIT];
  assign ctrl_sync  = wr_data[CTRL_SYNC_BIT];

  // High byte write commits the staged pair
  assign val_commit = wr_en && (wr_addr == A_VHI);
  assign val_word   = {wr_data, lo_q};

  assign flag_wr    = wr_en && (wr_addr == A_FLAG);
  assign flag_wdata = wr_data[NEV-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      per_q  <= '1;
      mask_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_VLO)  lo_q                <= wr_data;
      if (wr_addr == A_PLO)  per_q[BYTE_W-1:0]   <= wr_data;
      if (wr_addr == A_PHI)  per_q[CNT_W-1:BYTE_W] <= wr_data;
      if (wr_addr == A_MASK) mask_q              <= wr_data[NEV-1:0];
    end
  end

  // One byte pair per compare unit
  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    localparam logic [ADDR_W-1:0] A_CLO = ADDR_W'(cmp_lo_addr(k));
    localparam logic [ADDR_W-1:0] A_CHI = ADDR_W'(cmp_lo_addr(k) + 1);
    logic [CNT_W-1:0] cmp_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q <= '1;
      end else if (wr_en) begin
        if (wr_addr == A_CLO) cmp_q[BYTE_W-1:0]     <= wr_data;
        if (wr_addr == A_CHI) cmp_q[CNT_W-1:BYTE_W] <= wr_data;
      end
    end
    assign cmp_vals[k*CNT_W +: CNT_W] = cmp_q;
  end

  assign period = per_q;
  assign mask   = mask_q;
endmodule

// File: rtl/spt_runctl.sv
module spt_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic ctrl_wr,
  input  logic ctrl_run,
  input  logic ctrl_sync,
  output logic running
);
  logic run_q;
  logic pend_q;
  logic pend_val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      pend_q     <= 1'b0;
      pend_val_q <= 1'b0;
    end else if (ctrl_wr) begin
      if (ctrl_sync) begin
        // Defer to a tick seen in a later cycle
        pend_q     <= 1'b1;
        pend_val_q <= ctrl_run;
      end else begin
        run_q  <= ctrl_run;
        pend_q <= 1'b0;
      end
    end else if (pend_q && ref_tick) begin
      run_q  <= pend_val_q;
      pend_q <= 1'b0;
    end
  end

  assign running = run_q;
endmodule

// File: rtl/spt_core.sv
module spt_core #(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 2,
  localparam int NEV    = NUM_CMP + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     running,
  input  logic                     val_commit,
  input  logic [CNT_W-1:0]         val_word,
  input  logic [CNT_W-1:0]         period,
  input  logic [NUM_CMP*CNT_W-1:0] cmp_vals,
  output logic [CNT_W-1:0]         count,
  output logic                     delta_busy,
  output logic [NEV-1:0]           events,
  output logic                     ovf_pulse,
  output logic [NUM_CMP-1:0]       cmp_pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] delta_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             advance;
  logic             at_period;
  logic             ev_ovf;
  logic [NUM_CMP-1:0] ev_cmp;
  logic             ovf_q;
  logic [NUM_CMP-1:0] cmp_q;

  assign advance   = running && (delta_q == '0);
  assign at_period = (cnt_q == period);
  assign cnt_nxt   = at_period ? '0 : cnt_q + 1'b1;
  assign ev_ovf    = advance && at_period;

  // Main counter: direct load only while idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!running && val_commit) begin
      cnt_q <= val_word;
    end else if (advance) begin
      cnt_q <= cnt_nxt;
    end
  end

  // Delta down-counter: loaded by a commit while running
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delta_q <= '0;
    end else if (running && val_commit) begin
      delta_q <= val_word;
    end else if (running && (delta_q != '0)) begin
      delta_q <= delta_q - 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_match
    assign ev_cmp[k] = advance && (cnt_nxt == cmp_vals[k*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      cmp_q <= '0;
    end else begin
      ovf_q <= ev_ovf;
      cmp_q <= ev_cmp;
    end
  end

  assign events     = {ev_cmp, ev_ovf};
  assign count      = cnt_q;
  assign delta_busy = (delta_q != '0);
  assign ovf_pulse  = ovf_q;
  assign cmp_pulse  = cmp_q;
endmodule

// File: rtl/spt_flags.sv
module spt_flags #(
  parameter int NEV = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] events,
  input  logic           flag_wr,
  input  logic [NEV-1:0] flag_wdata,
  input  logic [NEV-1:0] mask,
  output logic [NEV-1:0] flags,
  output logic           irq
);
  logic [NEV-1:0] flag_q;

  for (genvar i = 0; i < NEV; i++) begin : g_flag
    logic clr;
    assign clr = flag_wr && !flag_wdata[i];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else begin
        // New event outranks a clear in the same cycle
        flag_q[i] <= events[i] | (flag_q[i] & ~clr);
      end
    end
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & mask);
endmodule

// File: rtl/stall_period_timer.sv
module stall_period_timer
  import spt_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = 4,
  localparam int CNT_W  = 2 * BYTE_W,
  localparam int NEV    = NUM_CMP + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic               running,
  output logic [CNT_W-1:0]   count,
  output logic               delta_busy,
  output logic               ovf_pulse,
  output logic [NUM_CMP-1:0] cmp_pulse,
  output logic [NEV-1:0]     flags,
  output logic               irq
);
  logic                     ctrl_wr;
  logic                     ctrl_run;
  logic                     ctrl_sync;
  logic                     val_commit;
  logic [CNT_W-1:0]         val_word;
  logic [CNT_W-1:0]         period;
  logic [NUM_CMP*CNT_W-1:0] cmp_vals;
  logic [NEV-1:0]           mask;
  logic                     flag_wr;
  logic [NEV-1:0]           flag_wdata;
  logic [NEV-1:0]           events;

  spt_regs #(
    .BYTE_W (BYTE_W),
    .NUM_CMP(NUM_CMP),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctrl_wr   (ctrl_wr),
    .ctrl_run  (ctrl_run),
    .ctrl_sync (ctrl_sync),
    .val_commit(val_commit),
    .val_word  (val_word),
    .period    (period),
    .cmp_vals  (cmp_vals),
    .mask      (mask),
    .flag_wr   (flag_wr),
    .flag_wdata(flag_wdata)
  );

  spt_runctl u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .ctrl_wr  (ctrl_wr),
    .ctrl_run (ctrl_run),
    .ctrl_sync(ctrl_sync),
    .running  (running)
  );

  spt_core #(
    .CNT_W  (CNT_W),
    .NUM_CMP(NUM_CMP)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (running),
    .val_commit(val_commit),
    .val_word  (val_word),
    .period    (period),
    .cmp_vals  (cmp_vals),
    .count     (count),
    .delta_busy(delta_busy),
    .events    (events),
    .ovf_pulse (ovf_pulse),
    .cmp_pulse (cmp_pulse)
  );

  spt_flags #(
    .NEV(NEV)
  ) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .events    (events),
    .flag_wr   (flag_wr),
    .flag_wdata(flag_wdata),
    .mask      (mask),
    .flags     (flags),
    .irq       (irq)
  );
endmodule

// File: rtl/spt_checker.sv
module spt_checker
  import spt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = 4,
  localparam int NEV    = NUM_CMP + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ref_tick,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic                     running,
  input logic [CNT_W-1:0]         count,
  input logic                     delta_busy,
  input logic                     ovf_pulse,
  input logic [NUM_CMP-1:0]       cmp_pulse,
  input logic [NEV-1:0]           flags,
  input logic                     irq,
  input logic [NUM_CMP*CNT_W-1:0] cmp_vals
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_VHI  = ADDR_W'(ADDR_VAL_HI);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(flag_addr(NUM_CMP));

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick && !(wr_en && wr_addr == A_CTRL)) |=> $stable(running)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !(wr_en && wr_addr == A_VHI)) |=> $stable(count)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && delta_busy) |=> $stable(count)); // R8

  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (count == '0)); // R5

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> flags[FLAG_OVF]); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_FLAG) |=> ((flags & $past(flags)) == $past(flags))); // R9

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0)); // R10

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp_chk
    AST_CMP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_pulse[k] |-> (count == cmp_vals[k*CNT_W +: CNT_W])); // R6
    AST_CMP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_pulse[k] |-> flags[k+1]); // R6
  end
endmodule

bind stall_period_timer spt_checker #(
  .CNT_W  (CNT_W),
  .NUM_CMP(NUM_CMP),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_tick  (ref_tick),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .running   (running),
  .count     (count),
  .delta_busy(delta_busy),
  .ovf_pulse (ovf_pulse),
  .cmp_pulse (cmp_pulse),
  .flags     (flags),
  .irq       (irq),
  .cmp_vals  (cmp_vals)
);

// File: tb/stall_period_timer_test.sv
`timescale 1ns/1ps
module stall_period_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        running;
  logic [15:0] count;
  logic        delta_busy;
  logic        ovf_pulse;
  logic [1:0]  cmp_pulse;
  logic [2:0]  flags;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  stall_period_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .running   (running),
    .count     (count),
    .delta_busy(delta_busy),
    .ovf_pulse (ovf_pulse),
    .cmp_pulse (cmp_pulse),
    .flags     (flags),
    .irq       (irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic setup(input int p, input int ca, input int cb, input int m);
    wr(4'd0, 8'h00);
    wr(4'd9, 8'h00);
    wr(4'd3, 8'(p));      wr(4'd4, 8'(p >> 8));
    wr(4'd5, 8'(ca));     wr(4'd6, 8'(ca >> 8));
    wr(4'd7, 8'(cb));     wr(4'd8, 8'(cb >> 8));
    wr(4'd10, 8'(m));
    wr(4'd1, 8'h00);      wr(4'd2, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 running", int'(running), 0);
    chk("R1 count", int'(count), 0);
    chk("R1 flags", int'(flags), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 ovf_pulse", int'(ovf_pulse), 0);
    chk("R1 cmp_pulse", int'(cmp_pulse), 0);
    chk("R1 delta_busy", int'(delta_busy), 0);

    // R7 direct value load while idle, then R4 idle hold
    wr(4'd1, 8'h34);
    wr(4'd2, 8'h12);
    chk("R7 idle load", int'(count), 16'h1234);
    step(); step();
    chk("R4 idle hold", int'(count), 16'h1234);

    // R2 immediate start/stop
    wr(4'd0, 8'h01);
    chk("R2 start", int'(running), 1);
    wr(4'd0, 8'h00);
    chk("R2 stop", int'(running), 0);

    // Sweep period and compare placement
    for (int p = 0; p <= 4; p++) begin
      for (int a = 0; a <= p + 1; a++) begin
        int b;
        int per;
        b   = p + 1 - a;
        per = p + 1;
        setup(p, a, b, 7);
        chk("R9 cleared before run", int'(flags), 0);
        wr(4'd0, 8'h01);
        for (int j = 0; j <= 2 * per; j++) begin
          int ph;
          ph = j % per;
          chk("R4 count", int'(count), ph);
          chk("R5 ovf_pulse", int'(ovf_pulse), int'(j > 0 && ph == 0));
          chk("R6 cmp0", int'(cmp_pulse[0]), int'(j > 0 && ph == a));
          chk("R6 cmp1", int'(cmp_pulse[1]), int'(j > 0 && ph == b));
          step();
        end
        chk("R5 R6 flags", int'(flags),
            1 + (a <= p ? 2 : 0) + (b <= p ? 4 : 0));
        chk("R10 irq all", int'(irq), 1);
        wr(4'd10, 8'h00);
        chk("R10 irq masked", int'(irq), 0);
        wr(4'd10, 8'h02);
        chk("R10 irq cmp0 only", int'(irq), int'(a <= p));
      end
    end

    // R3 reference-aligned start and stop
    setup(10, 16'hFFFF, 16'hFFFF, 0);
    wr(4'd0, 8'h03);
    chk("R3 start pending", int'(running), 0);
    step(); step(); step();
    chk("R3 waits tick", int'(running), 0);
    ref_tick = 1'b1;
    step();
    ref_tick = 1'b0;
    chk("R3 start on tick", int'(running), 1);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h02; ref_tick = 1'b1;
    step();
    wr_en = 1'b0; ref_tick = 1'b0;
    chk("R3 same-cycle tick ignored", int'(running), 1);
    step();
    chk("R3 still pending", int'(running), 1);
    ref_tick = 1'b1;
    step();
    ref_tick = 1'b0;
    chk("R3 stop on tick", int'(running), 0);

    // R9 clear versus simultaneous event
    setup(3, 1, 16'hFFFF, 1);
    wr(4'd0, 8'h01);
    step(); step(); step();
    chk("R5 at period", int'(count), 3);
    wr(4'd9, 8'h00);
    chk("R9 ovf wins clear", int'(flags), 1);
    chk("R10 irq ovf", int'(irq), 1);
    wr(4'd9, 8'h00);
    chk("R9 cmp wins clear", int'(flags), 2);
    chk("R10 irq masked cmp", int'(irq), 0);

    // R8 delta stall lengths
    setup(200, 16'hFFFF, 16'hFFFF, 0);
    wr(4'd0, 8'h01);
    step(); step(); step();
    for (int d = 0; d <= 4; d++) begin
      int c;
      wr(4'd1, 8'(d));
      c = int'(count);
      wr(4'd2, 8'h00);
      for (int i = 0; i < d; i++) begin
        chk("R8 stalled count", int'(count), c + 1);
        chk("R8 busy", int'(delta_busy), 1);
        step();
      end
      chk("R8 count at release", int'(count), c + 1);
      chk("R8 busy released", int'(delta_busy), 0);
      step();
      chk("R8 resumed", int'(count), c + 2);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule